// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block turns an accepted level-1 interrupt request into the hardware part of exception entry. It sits between a processor core and the core's memory write port. An outside interrupt controller raises a request and supplies a vector offset. The block then decides whether the request may be taken, using the global and level-1 mask bits of the current status register. Once a request is accepted, the block waits for the instructions already in the pipeline to finish. This wait ends when the core reports that its pipeline is empty.

After that, the block pushes an eight-word return context onto the system stack. It makes one write per cycle over a valid/ready handshake, pre-decrementing the stack pointer before each write. When the last write has been accepted, the block reports three values with a one-cycle done pulse: the rewritten status register, the new stack pointer and the handler address. The core loads these into its architectural state. The handler itself and the return path are not part of this block.

Top module: `irq_entry_seq`

## Requirements
- R1: A request on `irq_req` is accepted only when the block is idle and both the global mask (status bit 16) and the level-1 mask (status bit 18) are clear. Otherwise it produces no stack write and no done pulse.
- R2: After acceptance, no stack write is presented until a cycle in which `pipe_empty` is high. The context registers (`save_*`, `ret_pc`, `cur_sr`, `cur_sp`) are sampled in that cycle.
- R3: Exactly eight writes are made. Write k (k = 0..7) goes to address SP − 4·(k+1), and the data order is r8, r9, r10, r11, r12, lr, return PC, status register.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R5: The reported `new_sr` is the sampled status register with these changes: the mode field (bits 24:22) is set to 3'b011, the level-1 mask (bit 18) and level-0 mask (bit 17) are set, and bit 15 and bit 28 are cleared. All other bits are unchanged, including the global mask.
- R6: The reported `new_pc` equals `vec_base` plus the zero-extended `irq_offset`, both sampled at acceptance, modulo 2^32.
- R7: `done` is high for exactly one cycle, namely the cycle after the eighth write is accepted. In that same cycle `new_sp` equals the sampled SP minus 32, and `new_sr` and `new_pc` carry their new values.
- R8: The status word written to the stack is the value from before the entry changes of R5.
- R9: A request raised while a sequence is in progress is dropped. It causes no further writes after the done pulse unless the request is raised again while the block is idle.
- R10: A synchronous active-high `rst` returns the block to idle. After reset, `wr_valid` and `done` are low and `new_sr`, `new_sp` and `new_pc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | Level-1 interrupt request from the controller |
| irq_offset | input | OFS_W | Vector offset supplied by the controller |
| cur_sr | input | XLEN | Current status register |
| vec_base | input | XLEN | Exception vector base address |
| pipe_empty | input | 1 | High when no instruction is left in flight |
| ret_pc | input | XLEN | Address of the first instruction that did not complete |
| save_r8 | input | XLEN | Register r8 value to save |
| save_r9 | input | XLEN | Register r9 value to save |
| save_r10 | input | XLEN | Register r10 value to save |
| save_r11 | input | XLEN | Register r11 value to save |
| save_r12 | input | XLEN | Register r12 value to save |
| save_lr | input | XLEN | Link register value to save |
| cur_sp | input | XLEN | Current system stack pointer |
| wr_valid | output | 1 | Stack write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | XLEN | Stack write byte address |
| wr_data | output | XLEN | Stack write data |
| done | output | 1 | One-cycle pulse: entry complete |
| new_sr | output | XLEN | Status register to load |
| new_sp | output | XLEN | Stack pointer to load |
| new_pc | output | XLEN | Handler address |

## Verification
The assertions rely on two properties of the inputs. The stack pointer presented at the drain point must be word aligned. The memory side must only ever lower `wr_ready`, never withdraw a write. The stimulus meets the first condition by masking the two low bits of every random stack pointer. It meets the second by driving `wr_ready` randomly, with no other effect on the write channel. The bench also keeps `pipe_empty` and the context inputs steady from the drain point to the done pulse, as a real core would. It can therefore compare every stack word against the values it drove.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRAIN = 2'd1,
      ST_PUSH  = 2'd2,
      ST_FIN   = 2'd3
   } entry_state_t;

   // Push order of the return frame is architectural: slot 0 is written first.
   localparam int NUM_SLOTS = 8;
   localparam int SLOT_R8   = 0;
   localparam int SLOT_R9   = 1;
   localparam int SLOT_R10  = 2;
   localparam int SLOT_R11  = 3;
   localparam int SLOT_R12  = 4;
   localparam int SLOT_LR   = 5;
   localparam int SLOT_PC   = 6;
   localparam int SLOT_SR   = 7;

   localparam logic [2:0] MODE_LEVEL1 = 3'b011;

endpackage

// File: rtl/irq_gate.sv
module irq_gate (
   input  logic req,
   input  logic idle,
   input  logic global_mask,
   input  logic level_mask,
   output logic accept
);
   assign accept = req & idle & ~global_mask & ~level_mask;
endmodule

// File: rtl/sr_rewrite.sv
module sr_rewrite #(
   parameter int XLEN     = 32,
   parameter int POS_R    = 15,
   parameter int POS_I0M  = 17,
   parameter int POS_I1M  = 18,
   parameter int POS_MODE = 22,
   parameter int POS_J    = 28
) (
   input  logic [XLEN-1:0] sr_in,
   output logic [XLEN-1:0] sr_out
);
   always_comb begin
      sr_out                = sr_in;
      sr_out[POS_MODE +: 3] = irq_entry_pkg::MODE_LEVEL1;
      sr_out[POS_I1M]       = 1'b1;
      sr_out[POS_I0M]       = 1'b1;
      sr_out[POS_R]         = 1'b0;
      sr_out[POS_J]         = 1'b0;
   end
endmodule

// File: rtl/stack_pusher.sv
module stack_pusher #(
   parameter int XLEN      = 32,
   parameter int SLOTS     = 8,
   parameter int ADDR_MODE = 0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start,
   input  logic [XLEN-1:0]       sp_load,
   input  logic [SLOTS*XLEN-1:0] ctx_flat,
   input  logic                  wr_ready,
   output logic                  wr_valid,
   output logic [XLEN-1:0]       wr_addr,
   output logic [XLEN-1:0]       wr_data,
   output logic                  last_ack
);
   localparam int STEP  = XLEN / 8;
   localparam int SHIFT = $clog2(STEP);
   localparam int IDX_W = $clog2(SLOTS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

   logic             active;
   logic [IDX_W-1:0] idx;
   logic             ack;

   assign ack      = active & wr_ready;
   assign last_ack = ack & (idx == LAST_IDX);
   assign wr_valid = active;
   assign wr_data  = ctx_flat[idx*XLEN +: XLEN];

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (ack) begin
         if (idx == LAST_IDX) active <= 1'b0;
         idx <= idx + 1'b1;
      end
   end

   generate
      if (ADDR_MODE == 0) begin : g_sub
         logic [XLEN-1:0] base_r;
         always_ff @(posedge clk) begin
            if (rst)        base_r <= '0;
            else if (start) base_r <= sp_load;
         end
         assign wr_addr = base_r - ((XLEN'(idx) + XLEN'(1)) << SHIFT);
      end else begin : g_ptr
         logic [XLEN-1:0] ptr_r;
         always_ff @(posedge clk) begin
            if (rst)        ptr_r <= '0;
            else if (start) ptr_r <= sp_load - XLEN'(STEP);
            else if (ack)   ptr_r <= ptr_r - XLEN'(STEP);
         end
         assign wr_addr = ptr_r;
      end
   endgenerate
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int XLEN      = 32,
   parameter int OFS_W     = 14,
   parameter int ADDR_MODE = 0,
   parameter int POS_R     = 15,
   parameter int POS_GM    = 16,
   parameter int POS_I0M   = 17,
   parameter int POS_I1M   = 18,
   parameter int POS_MODE  = 22,
   parameter int POS_J     = 28
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             irq_req,
   input  logic [OFS_W-1:0] irq_offset,
   input  logic [XLEN-1:0]  cur_sr,
   input  logic [XLEN-1:0]  vec_base,
   input  logic             pipe_empty,
   input  logic [XLEN-1:0]  ret_pc,
   input  logic [XLEN-1:0]  save_r8,
   input  logic [XLEN-1:0]  save_r9,
   input  logic [XLEN-1:0]  save_r10,
   input  logic [XLEN-1:0]  save_r11,
   input  logic [XLEN-1:0]  save_r12,
   input  logic [XLEN-1:0]  save_lr,
   input  logic [XLEN-1:0]  cur_sp,
   output logic             wr_valid,
   input  logic             wr_ready,
   output logic [XLEN-1:0]  wr_addr,
   output logic [XLEN-1:0]  wr_data,
   output logic             done,
   output logic [XLEN-1:0]  new_sr,
   output logic [XLEN-1:0]  new_sp,
   output logic [XLEN-1:0]  new_pc
);
   import irq_entry_pkg::*;

   localparam int STEP  = XLEN / 8;
   localparam int FRAME = NUM_SLOTS * STEP;

   generate
      if (XLEN < 16 || (XLEN % 8) != 0)
         $error("XLEN must be a multiple of 8, at least 16");
      if (OFS_W < 1 || OFS_W > XLEN)
         $error("OFS_W must lie in 1..XLEN");
      if (ADDR_MODE != 0 && ADDR_MODE != 1)
         $error("ADDR_MODE must be 0 or 1");
      if (POS_MODE + 3 > XLEN || POS_R >= XLEN || POS_J >= XLEN ||
          POS_GM >= XLEN || POS_I0M >= XLEN || POS_I1M >= XLEN)
         $error("status bit position outside XLEN");
   endgenerate

   entry_state_t    st;
   logic            accept;
   logic            capture;
   logic            last_ack;
   logic [XLEN-1:0] base_q;
   logic [OFS_W-1:0] ofs_q;
   logic [XLEN-1:0] sp_q;
   logic [XLEN-1:0] ctx_q  [NUM_SLOTS];
   logic [XLEN-1:0] ctx_in [NUM_SLOTS];
   logic [NUM_SLOTS*XLEN-1:0] ctx_flat;
   logic [XLEN-1:0] sr_next;

   irq_gate u_gate (
      .req         (irq_req),
      .idle        (st == ST_IDLE),
      .global_mask (cur_sr[POS_GM]),
      .level_mask  (cur_sr[POS_I1M]),
      .accept      (accept)
   );

   assign capture = (st == ST_DRAIN) && pipe_empty;

   always_comb begin
      ctx_in[SLOT_R8]  = save_r8;
      ctx_in[SLOT_R9]  = save_r9;
      ctx_in[SLOT_R10] = save_r10;
      ctx_in[SLOT_R11] = save_r11;
      ctx_in[SLOT_R12] = save_r12;
      ctx_in[SLOT_LR]  = save_lr;
      ctx_in[SLOT_PC]  = ret_pc;
      ctx_in[SLOT_SR]  = cur_sr;
   end

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst)          ctx_q[g] <= '0;
            else if (capture) ctx_q[g] <= ctx_in[g];
         end
         assign ctx_flat[g*XLEN +: XLEN] = ctx_q[g];
      end
   endgenerate

   stack_pusher #(
      .XLEN      (XLEN),
      .SLOTS     (NUM_SLOTS),
      .ADDR_MODE (ADDR_MODE)
   ) u_push (
      .clk      (clk),
      .rst      (rst),
      .start    (capture),
      .sp_load  (cur_sp),
      .ctx_flat (ctx_flat),
      .wr_ready (wr_ready),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .last_ack (last_ack)
   );

   sr_rewrite #(
      .XLEN     (XLEN),
      .POS_R    (POS_R),
      .POS_I0M  (POS_I0M),
      .POS_I1M  (POS_I1M),
      .POS_MODE (POS_MODE),
      .POS_J    (POS_J)
   ) u_sr (
      .sr_in  (ctx_q[SLOT_SR]),
      .sr_out (sr_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_IDLE;
         base_q <= '0;
         ofs_q  <= '0;
         sp_q   <= '0;
         new_sr <= '0;
         new_sp <= '0;
         new_pc <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (accept) begin
               st     <= ST_DRAIN;
               base_q <= vec_base;
               ofs_q  <= irq_offset;
            end
            ST_DRAIN: if (pipe_empty) begin
               st   <= ST_PUSH;
               sp_q <= cur_sp;
            end
            ST_PUSH: if (last_ack) begin
               st     <= ST_FIN;
               new_sr <= sr_next;
               new_sp <= sp_q - XLEN'(FRAME);
               new_pc <= base_q + XLEN'(ofs_q);
            end
            ST_FIN: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done = (st == ST_FIN);

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int XLEN     = 32,
   parameter int POS_R    = 15,
   parameter int POS_I0M  = 17,
   parameter int POS_I1M  = 18,
   parameter int POS_MODE = 22,
   parameter int POS_J    = 28
) (
   input logic            clk,
   input logic            rst,
   input logic            wr_valid,
   input logic            wr_ready,
   input logic [XLEN-1:0] wr_addr,
   input logic [XLEN-1:0] wr_data,
   input logic            done,
   input logic [XLEN-1:0] new_sr
);
   localparam int SLOTS   = irq_entry_pkg::NUM_SLOTS;
   localparam int ALIGN_W = $clog2(XLEN / 8);
   localparam int CNT_W   = $clog2(SLOTS + 1);

   logic [CNT_W-1:0] acc_cnt;

   always_ff @(posedge clk) begin
      if (rst || done)             acc_cnt <= '0;
      else if (wr_valid && wr_ready) acc_cnt <= acc_cnt + 1'b1;
   end

   p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

   p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_frame_count_r3: assert property (@(posedge clk) disable iff (rst)
      done |-> (acc_cnt == CNT_W'(SLOTS)));

   p_no_excess_write_r3: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> (acc_cnt < CNT_W'(SLOTS)));

   p_no_write_at_done_r7: assert property (@(posedge clk) disable iff (rst)
      done |-> !wr_valid);

   p_word_aligned_r3: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> (wr_addr[ALIGN_W-1:0] == '0));

   p_sr_fields_r5: assert property (@(posedge clk) disable iff (rst)
      done |-> (new_sr[POS_MODE +: 3] == 3'b011 && new_sr[POS_I1M] &&
                new_sr[POS_I0M] && !new_sr[POS_R] && !new_sr[POS_J]));

   p_reset_quiet_r10: assert property (@(posedge clk)
      rst |=> (!wr_valid && !done));

endmodule

bind irq_entry_seq irq_entry_chk #(
   .XLEN     (XLEN),
   .POS_R    (POS_R),
   .POS_I0M  (POS_I0M),
   .POS_I1M  (POS_I1M),
   .POS_MODE (POS_MODE),
   .POS_J    (POS_J)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_valid (wr_valid),
   .wr_ready (wr_ready),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .done     (done),
   .new_sr   (new_sr)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
   localparam int XLEN  = 32;
   localparam int OFS_W = 14;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             irq_req = 1'b0;
   logic [OFS_W-1:0] irq_offset = '0;
   logic [XLEN-1:0]  cur_sr = '0, vec_base = '0, ret_pc = '0, cur_sp = '0;
   logic [XLEN-1:0]  save_r8 = '0, save_r9 = '0, save_r10 = '0;
   logic [XLEN-1:0]  save_r11 = '0, save_r12 = '0, save_lr = '0;
   logic             pipe_empty = 1'b0;
   logic             wr_ready = 1'b0;
   logic             wr_valid, done;
   logic [XLEN-1:0]  wr_addr, wr_data, new_sr, new_sp, new_pc;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   irq_entry_seq uut (
      .clk(clk), .rst(rst), .irq_req(irq_req), .irq_offset(irq_offset),
      .cur_sr(cur_sr), .vec_base(vec_base), .pipe_empty(pipe_empty),
      .ret_pc(ret_pc), .save_r8(save_r8), .save_r9(save_r9),
      .save_r10(save_r10), .save_r11(save_r11), .save_r12(save_r12),
      .save_lr(save_lr), .cur_sp(cur_sp), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .done(done), .new_sr(new_sr), .new_sp(new_sp), .new_pc(new_pc)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // R5: mode 24:22 = 011, set 18 and 17, clear 15 and 28
   function automatic logic [XLEN-1:0] exp_sr(input logic [XLEN-1:0] s);
      logic [XLEN-1:0] r = s;
      r[24:22] = 3'b011;
      r[18] = 1'b1;
      r[17] = 1'b1;
      r[15] = 1'b0;
      r[28] = 1'b0;
      return r;
   endfunction

   function automatic bit is_masked(input logic [XLEN-1:0] s);
      return s[16] | s[18];
   endfunction

   task automatic run_masked(input logic [XLEN-1:0] sr);
      logic [XLEN-1:0] pc_before = new_pc;
      @(negedge clk);
      cur_sr = sr; pipe_empty = 1'b1; irq_req = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (i == 3) irq_req = 1'b0;
         chk(!wr_valid && !done, "R1 masked request", {31'd0, wr_valid}, '0);
      end
      chk(new_pc == pc_before, "R1 handler pc kept", new_pc, pc_before);
   endtask

   task automatic run_accepted(input logic [XLEN-1:0] sr, input int drain,
                               input bit poke, input logic [XLEN-1:0] base,
                               input logic [XLEN-1:0] sp);
      logic [XLEN-1:0] frame [8];
      logic [XLEN-1:0] stall_addr = '0, stall_data = '0;
      logic [XLEN-1:0] pc_exp;
      bit   stalled = 0, want_done = 0, saw_done = 0;
      int   n = 0;
      @(negedge clk);
      cur_sr = sr; vec_base = base; cur_sp = sp;
      irq_offset = OFS_W'($urandom);
      save_r8 = $urandom; save_r9 = $urandom; save_r10 = $urandom;
      save_r11 = $urandom; save_r12 = $urandom; save_lr = $urandom;
      ret_pc = $urandom & ~32'h1;
      pipe_empty = (drain == 0);
      wr_ready = 1'b0;
      irq_req = 1'b1;
      frame[0] = save_r8;  frame[1] = save_r9;  frame[2] = save_r10;
      frame[3] = save_r11; frame[4] = save_r12; frame[5] = save_lr;
      frame[6] = ret_pc;   frame[7] = sr;
      pc_exp = base + XLEN'(irq_offset);
      @(negedge clk);
      irq_req = 1'b0;
      for (int i = 0; i < drain; i++) begin
         chk(!wr_valid, "R2 no write before drain", {31'd0, wr_valid}, '0);
         @(negedge clk);
      end
      pipe_empty = 1'b1;
      for (int g = 0; g < 400 && !saw_done; g++) begin
         if (want_done) begin
            chk(done, "R7 done after last write", {31'd0, done}, 32'd1);
            chk(new_sp == sp - 32'd32, "R7 new sp", new_sp, sp - 32'd32);
            chk(new_sr == exp_sr(sr), "R5 new sr", new_sr, exp_sr(sr));
            chk(new_pc == pc_exp, "R6 new pc", new_pc, pc_exp);
            chk(!wr_valid, "R3 no ninth write", {31'd0, wr_valid}, '0);
            saw_done = 1;
            irq_req = 1'b0;
         end else begin
            chk(!done, "R7 early done", {31'd0, done}, '0);
            wr_ready = ($urandom % 3) != 0;
            if (poke && n == 3) irq_req = 1'b1;
            if (stalled) begin
               chk(wr_valid && wr_addr == stall_addr, "R4 addr held", wr_addr, stall_addr);
               chk(wr_data == stall_data, "R4 data held", wr_data, stall_data);
            end
            stalled = 0;
            if (wr_valid) begin
               if (wr_ready) begin
                  chk(wr_addr == sp - 32'd4 * 32'(n + 1), "R3 push address",
                      wr_addr, sp - 32'd4 * 32'(n + 1));
                  chk(wr_data == frame[n], n == 7 ? "R8 saved sr" : "R3 push data",
                      wr_data, frame[n]);
                  n++;
                  if (n == 8) want_done = 1;
               end else begin
                  stalled = 1; stall_addr = wr_addr; stall_data = wr_data;
               end
            end
         end
         @(negedge clk);
      end
      chk(saw_done, "R7 done reached", {31'd0, saw_done}, 32'd1);
      chk(!done, "R7 done one cycle", {31'd0, done}, '0);
      wr_ready = 1'b1;
      for (int i = 0; i < 12; i++) begin
         chk(!wr_valid && !done, poke ? "R9 busy request dropped" : "R1 idle after entry",
             {31'd0, wr_valid}, '0);
         @(negedge clk);
      end
      pipe_empty = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      chk(!wr_valid && !done, "R10 reset outputs", {31'd0, wr_valid}, '0);
      chk(new_sr == 0 && new_sp == 0 && new_pc == 0, "R10 reset values", new_pc, '0);

      // directed masking corners
      run_masked(32'h0001_0000);
      run_masked(32'h0004_0000);
      run_masked(32'h0005_0000);
      // directed accepted entries
      run_accepted(32'h1000_8000, 0, 0, 32'h8000_0000, 32'h0000_1000);
      run_accepted(32'hFFFA_FFFF & ~32'h0005_0000, 5, 0, 32'hFFFF_FFF0, 32'h0000_0010);
      run_accepted(32'h0000_0000, 2, 1, 32'h0000_4000, 32'h2000_0000);
      run_accepted(32'hFFFF_FFFF & ~32'h0005_0000, 1, 0, 32'h1234_0000, 32'h0);

      // random mix
      for (int t = 0; t < 60; t++) begin
         logic [XLEN-1:0] s = $urandom;
         if (($urandom % 3) != 0) s = s & ~32'h0005_0000;
         if (is_masked(s)) run_masked(s);
         else run_accepted(s, $urandom % 6, ($urandom % 4) == 0,
                           $urandom, $urandom & ~32'h3);
      end

      // reset during a push sequence
      @(negedge clk);
      cur_sr = 32'h0; pipe_empty = 1'b1; wr_ready = 1'b0; irq_req = 1'b1;
      @(negedge clk); irq_req = 1'b0;
      repeat (3) @(negedge clk);
      chk(wr_valid, "R10 push in progress", {31'd0, wr_valid}, 32'd1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!wr_valid && !done, "R10 mid-sequence reset", {31'd0, wr_valid}, '0);
      chk(new_pc == 0 && new_sp == 0, "R10 outputs cleared", new_sp, '0);
      wr_ready = 1'b1;
      repeat (6) @(negedge clk);
      chk(!wr_valid, "R10 stays idle", {31'd0, wr_valid}, '0);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule